// File: doc/BRIEF.md
# BT.656 Output Range Limiter and VBI Chroma Blanker

This block sits just before the serializer of an 8-bit BT.656-style video stream. It receives one decoded sample per clock. Each sample arrives with a tag that marks it as luma (Y) or colour difference (Cb/Cr), a flag for samples that belong to an AV code header, and a flag for samples on a vertical blanking interval line. It returns the sample after a single register stage. Any value outside the legal window for that sample type is clamped to the nearest edge of the window. In-range values are never rescaled.

Two configuration bits are held in the block. They are written together through a one-cycle load strobe. The range bit selects one of two windows. The narrow window is the nominal studio range. The wide window excludes only the two reserved codes. The blank bit forces chroma on VBI lines to the neutral level, so that ancillary data carried on those lines does not pick up false colour when it is re-encoded. Header samples pass through untouched, because only they may carry the reserved codes 0x00 and 0xFF. Generating AV codes and detecting VBI lines are handled elsewhere.

Top module: `bt656_range_limiter`

## Requirements
- R1: With the range bit at 0 (narrow), a luma sample (tag 0) is clamped to 16..235.
- R2: With the range bit at 0, a chroma sample (tag 1) is clamped to 16..240.
- R3: With the range bit at 1 (wide), both luma and chroma are clamped to 1..254.
- R4: A sample inside its window leaves the block unchanged. A sample below the window becomes the lower limit, and a sample above it becomes the upper limit. No scaling is applied.
- R5: After reset, the range bit is 1 (wide), and it keeps that value until a load strobe writes a new one.
- R6: With the blank bit at 1, every chroma sample on a VBI line (VBI flag 1, tag 1) that is not a header sample is output as 0x80. Luma on VBI lines is only clamped.
- R7: After reset, the blank bit is 1. With the blank bit at 0, chroma on VBI lines is clamped like any other chroma.
- R8: A sample with the AV-header flag set is output unchanged, including 0x00 and 0xFF, and it skips both clamping and blanking.
- R9: The output sample, tag and flags appear exactly one clock after the input. During and just after reset, the output is 0x10 with the tag and flags at 0.
- R10: 0x00 and 0xFF appear on the output only when the delayed AV-header flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Strobe that writes both configuration bits |
| cfg_wide | input | 1 | Range bit to load: 0 narrow, 1 wide |
| cfg_blank | input | 1 | Blank-chroma-on-VBI bit to load |
| in_sample | input | 8 | Sample value |
| in_is_chroma | input | 1 | Tag: 0 luma, 1 chroma |
| in_av_hdr | input | 1 | Sample belongs to an AV code header |
| in_vbi | input | 1 | Sample lies on a VBI line |
| out_sample | output | 8 | Limited sample, one clock later |
| out_is_chroma | output | 1 | Delayed tag |
| out_av_hdr | output | 1 | Delayed header flag |
| out_vbi | output | 1 | Delayed VBI flag |

## Verification
On every cycle, the assertions check the following. Outputs without the header flag never carry a reserved code. The output stays inside the window that the configuration of the previous cycle selects. Blanked VBI chroma equals 0x80. Header samples equal the input of one cycle before, and the tag and flags follow the inputs by one clock. The bench scenarios are needed to show the rest: the exact clamp value at each limit, that in-range values are not altered, the reset defaults of both configuration bits, and that clearing the blank bit lets VBI chroma through.

// File: rtl/bt656_range_limiter.sv
module bt656_range_limiter #(
  parameter int unsigned NARROW_MIN   = 16,
  parameter int unsigned NARROW_Y_MAX = 235,
  parameter int unsigned NARROW_C_MAX = 240,
  parameter int unsigned WIDE_MIN     = 1,
  parameter int unsigned WIDE_MAX     = 254,
  parameter int unsigned BLANK_LEVEL  = 128,
  parameter int unsigned IDLE_LEVEL   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic       cfg_wide,
  input  logic       cfg_blank,
  input  logic [7:0] in_sample,
  input  logic       in_is_chroma,
  input  logic       in_av_hdr,
  input  logic       in_vbi,
  output logic [7:0] out_sample,
  output logic       out_is_chroma,
  output logic       out_av_hdr,
  output logic       out_vbi
);
  localparam logic [7:0] N_MIN  = 8'(NARROW_MIN);
  localparam logic [7:0] N_YMAX = 8'(NARROW_Y_MAX);
  localparam logic [7:0] N_CMAX = 8'(NARROW_C_MAX);
  localparam logic [7:0] W_MIN  = 8'(WIDE_MIN);
  localparam logic [7:0] W_MAX  = 8'(WIDE_MAX);
  localparam logic [7:0] BLANK  = 8'(BLANK_LEVEL);
  localparam logic [7:0] IDLE   = 8'(IDLE_LEVEL);

  logic       wide_q, blank_q;
  logic [7:0] lo, hi, clamped, next_sample;
  logic       kill_chroma;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_q  <= 1'b1;
      blank_q <= 1'b1;
    end else if (cfg_load) begin
      wide_q  <= cfg_wide;
      blank_q <= cfg_blank;
    end
  end

  assign lo = wide_q ? W_MIN : N_MIN;
  assign hi = wide_q ? W_MAX : (in_is_chroma ? N_CMAX : N_YMAX);

  assign clamped = (in_sample < lo) ? lo :
                   (in_sample > hi) ? hi : in_sample;

  assign kill_chroma = blank_q && in_vbi && in_is_chroma;

  assign next_sample = in_av_hdr   ? in_sample :
                       kill_chroma ? BLANK     : clamped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sample    <= IDLE;
      out_is_chroma <= 1'b0;
      out_av_hdr    <= 1'b0;
      out_vbi       <= 1'b0;
    end else begin
      out_sample    <= next_sample;
      out_is_chroma <= in_is_chroma;
      out_av_hdr    <= in_av_hdr;
      out_vbi       <= in_vbi;
    end
  end

  // reserved codes only inside headers
  p_no_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_av_hdr |-> (out_sample != 8'h00 && out_sample != 8'hFF));

  p_narrow_luma_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wide_q) && !out_av_hdr && !out_is_chroma)
      |-> (out_sample >= N_MIN && out_sample <= N_YMAX));

  p_narrow_chroma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wide_q) && !out_av_hdr && out_is_chroma)
      |-> (out_sample >= N_MIN && out_sample <= N_CMAX));

  p_wide_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wide_q) && !out_av_hdr)
      |-> (out_sample >= W_MIN && out_sample <= W_MAX));

  p_vbi_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(blank_q) && out_vbi && out_is_chroma && !out_av_hdr)
      |-> (out_sample == BLANK));

  p_hdr_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_av_hdr) |-> (out_sample == $past(in_sample)));

  p_flag_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_is_chroma == $past(in_is_chroma) &&
                      out_av_hdr == $past(in_av_hdr) &&
                      out_vbi == $past(in_vbi)));
endmodule

// File: tb/bt656_range_limiter_tb.sv
module bt656_range_limiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_wide = 1'b0, cfg_blank = 1'b0;
  logic [7:0] in_sample = 8'h00;
  logic in_is_chroma = 1'b0, in_av_hdr = 1'b0, in_vbi = 1'b0;
  logic [7:0] out_sample;
  logic out_is_chroma, out_av_hdr, out_vbi;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bt656_range_limiter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_wide(cfg_wide),
    .cfg_blank(cfg_blank), .in_sample(in_sample), .in_is_chroma(in_is_chroma),
    .in_av_hdr(in_av_hdr), .in_vbi(in_vbi), .out_sample(out_sample),
    .out_is_chroma(out_is_chroma), .out_av_hdr(out_av_hdr), .out_vbi(out_vbi)
  );

  // {wide, blank, chroma, hdr, vbi, in[7:0], expected[7:0]}
  localparam logic [20:0] VEC [0:17] = '{
    {5'b00000, 8'h05, 8'h10}, {5'b00000, 8'hF0, 8'hEB}, {5'b00000, 8'h80, 8'h80},
    {5'b00100, 8'hF0, 8'hF0}, {5'b00100, 8'hF5, 8'hF0}, {5'b00100, 8'h00, 8'h10},
    {5'b10000, 8'h00, 8'h01}, {5'b10000, 8'hFF, 8'hFE}, {5'b10100, 8'hF0, 8'hF0},
    {5'b10000, 8'hF8, 8'hF8}, {5'b11101, 8'h20, 8'h80}, {5'b01101, 8'hFF, 8'h80},
    {5'b11001, 8'hFF, 8'hFE}, {5'b10101, 8'h20, 8'h20}, {5'b00101, 8'hFF, 8'hF0},
    {5'b01111, 8'hFF, 8'hFF}, {5'b00010, 8'h00, 8'h00}, {5'b10010, 8'hFF, 8'hFF}
  };

  function automatic string req_of(int i);
    case (i)
      0, 1:        return "R1";
      2, 9:        return "R4";
      3, 4, 5:     return "R2";
      6, 7, 8:     return "R3";
      10, 11, 12:  return "R6";
      13, 14:      return "R7";
      default:     return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(logic w, logic b);
    @(negedge clk);
    cfg_load = 1'b1; cfg_wide = w; cfg_blank = b;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic drive(logic [7:0] s, logic c, logic h, logic v);
    in_sample = s; in_is_chroma = c; in_av_hdr = h; in_vbi = v;
  endtask

  function automatic logic [7:0] ref_clamp(logic [7:0] s, logic c, logic w);
    logic [7:0] lo, hi;
    lo = w ? 8'd1 : 8'd16;
    hi = w ? 8'd254 : (c ? 8'd240 : 8'd235);
    if (s < lo) return lo;
    if (s > hi) return hi;
    return s;
  endfunction

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    drive(8'hFF, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset sample", 32'(out_sample), 32'h10);
    check("R9 reset flags", {29'd0, out_is_chroma, out_av_hdr, out_vbi}, 32'd0);
    rst_n = 1'b1;

    // R5 and R7 defaults, without any load strobe
    drive(8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R5 default wide", 32'(out_sample), 32'h01);
    drive(8'h30, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check("R7 default blank", 32'(out_sample), 32'h80);

    for (int i = 0; i < 18; i++) begin
      load_cfg(VEC[i][20], VEC[i][19]);
      drive(VEC[i][15:8], VEC[i][18], VEC[i][17], VEC[i][16]);
      @(negedge clk);
      check(req_of(i), 32'(out_sample), 32'(VEC[i][7:0]));
    end

    // R9 streaming: each output lags its input by exactly one clock
    load_cfg(1'b0, 1'b1);
    for (int k = 0; k < 260; k++) begin
      logic [7:0] ps;
      logic pc, pv;
      ps = 8'(k - 1); pc = k[1]; pv = k[2];
      if (k < 256) drive(8'(k), k[0] ^ k[1], 1'b0, k[2]);
      else drive(8'h80, 1'b0, 1'b0, 1'b0);
      if (k > 0 && k <= 256) begin
        pc = (k - 1) % 2 == 1 ? ~((k - 1) >> 1 & 1) != 0 : (((k - 1) >> 1) & 1) != 0;
        pc = ((k - 1) & 1) != (((k - 1) >> 1) & 1);
        pv = (((k - 1) >> 2) & 1) != 0;
        check("R9 stream tag", {30'd0, out_is_chroma, out_vbi}, {30'd0, pc, pv});
        check("R10 stream value",
              32'(out_sample), 32'((pv && pc) ? 8'h80 : ref_clamp(ps, pc, 1'b0)));
      end
      @(negedge clk);
    end

    // R10 in wide mode: reserved codes on luma and chroma
    load_cfg(1'b1, 1'b0);
    drive(8'hFF, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check("R10 wide chroma FF", 32'(out_sample), 32'hFE);
    drive(8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R10 wide luma 00", 32'(out_sample), 32'h01);

    // R5: a held config stays after the strobe drops
    drive(8'hF8, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R5 config held", 32'(out_sample), 32'hF8);

    // R9: reset mid-stream returns the idle value
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid reset", 32'(out_sample), 32'h10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule